// File: doc/BRIEF.md
# MSI Pending/Queued Interrupt Gate

This block decides the fate of each message-signalled interrupt event. Every interrupt source owns an entry in a vector table that lives in system memory. When an event arrives with its source number, the gate works out where that source's entry sits, fetches the 64-bit entry through a simple read port, and pulls out the target server, the priority, the generation bits and a two-bit pending/queued state. It then acts on the event in one of three ways. It can mark the entry pending and raise an interrupt request. It can mark the entry queued. Or it can drop the event. Every mark is a single-byte write back into the table.

The pending/queued state is never held in flip-flops: the table in memory is the only copy. The gate handles one event at a time. From the moment it accepts an event until the event is fully retired, including the acknowledgement of any write-back, it holds its ready low. A force input makes the gate ignore the stored state, which lets a presentation controller resend an interrupt that it rejected earlier. The positions of the fields inside the entry are parameters.

Top module: `msi_pq_gate`

## Requirements
- R1: The entry address is `cfg_tbl_base + 16*src`, or `cfg_tbl_base + 128*src` when `cfg_wide_entry` is 1. That address is issued on `rd_req_addr`, and it is held stable while `rd_req_ready` is low. The pending byte is written at entry+4 and the queued byte at entry+5.
- R2: If `cfg_tbl_en` is 0, or `src` is not below `cfg_tbl_len`, the event is accepted and abandoned. `err_pulse` goes high for one cycle, and there is no memory access and no interrupt.
- R3: The entry is big-endian: byte k of the entry occupies bits [63-8k:56-8k] of `rd_rsp_data`. By default the priority is byte 0 (bits 63:56) and the server field is bits 55:40. The pending bit P is bit 24, the generation field is bits 26:25 and the queued bit Q is bit 16. With P=0, Q=0 and a priority other than 0xFF, the gate writes the byte `0x01 | (gen << 1)` at entry+4. In the cycle after that write is acknowledged, it pulses `irq_valid` with `irq_server` = server field >> 2, `irq_num` = src + `cfg_irq_base`, and `irq_prio` = priority.
- R4: With P=0, Q=0 and priority 0xFF (masked), the gate writes 0x01 at entry+4+1, that is at entry+5, and raises no interrupt.
- R5: With P=1 and Q=0, the gate writes 0x01 at entry+5 and raises no interrupt.
- R6: With Q=1, whatever the value of P, the event is dropped: no write and no interrupt.
- R7: When `evt_force` is 1, the stored P and Q bits are treated as 0, so a set Q no longer drops the event.
- R8: An error response on the read (`rd_rsp_err`) abandons the event with one `err_pulse`, no write-back and no interrupt.
- R9: `evt_ready` is low from the cycle after an event is accepted until its read, and any write-back, have completed. A new event is never taken while a write is outstanding. The read and write ports are never active together.
- R10: After reset, `evt_ready` is 1 and `rd_req_valid`, `wr_req_valid`, `irq_valid` and `err_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tbl_en | input | 1 | Vector table enable |
| cfg_tbl_base | input | ADDR_W | Table base address |
| cfg_tbl_len | input | SRC_W+1 | Number of valid sources |
| cfg_wide_entry | input | 1 | 1 = 128-byte entries, 0 = 16-byte entries |
| cfg_irq_base | input | IRQ_W | Offset added to the source number for the interrupt number |
| evt_valid | input | 1 | Event request |
| evt_ready | output | 1 | Gate idle and accepting an event |
| evt_src | input | SRC_W | Source number of the event |
| evt_force | input | 1 | Ignore the stored pending/queued state |
| rd_req_valid | output | 1 | Entry read request |
| rd_req_ready | input | 1 | Read request taken |
| rd_req_addr | output | ADDR_W | Entry address |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | 64 | Entry, big-endian |
| rd_rsp_err | input | 1 | Read failed |
| wr_req_valid | output | 1 | Byte write request |
| wr_req_ready | input | 1 | Write request taken |
| wr_req_addr | output | ADDR_W | Byte address |
| wr_req_byte | output | 8 | Byte value |
| wr_ack_valid | input | 1 | Write completed |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_server | output | SERVER_W-2 | Target server |
| irq_num | output | IRQ_W | Interrupt number |
| irq_prio | output | PRIO_W | Interrupt priority |
| err_pulse | output | 1 | One-cycle abandon indication |

## Verification
The bench puts entries into a byte-addressed memory model and drives events through each pending/queued combination: 00 enabled, 00 masked, 10, 01 and 11. These patterns tell the send path apart from the two queue paths and from the drop path. The same 11 entry is then sent with force, which separates the forced path from the stored-state path. A wide-entry event tells 128-byte stride addressing apart from 16-byte stride addressing. Three abandon cases are applied: a disabled table, a source equal to the table length, and a read error. The bench shows that none of them touches memory or raises an interrupt. A timing case confirms that the interrupt comes one cycle after the write acknowledgement and that `evt_ready` stays low while the event is in flight.

// File: rtl/msi_pq_pkg.sv
package msi_pq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_WR_WAIT
    } gate_state_e;

    typedef enum logic [1:0] {
        ACT_DROP,
        ACT_SEND,
        ACT_QUEUE
    } gate_action_e;

endpackage

// File: rtl/msi_entry_addr.sv
module msi_entry_addr #(
    parameter int ADDR_W       = 32,
    parameter int SRC_W        = 11,
    parameter int WIDE_SHIFT   = 7,
    parameter int NARROW_SHIFT = 4
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [SRC_W-1:0]  src_i,
    input  logic              wide_i,
    output logic [ADDR_W-1:0] entry_o
);
    localparam int PAD_W = ADDR_W - SRC_W;

    logic [ADDR_W-1:0] src_ext;
    logic [ADDR_W-1:0] stride_ofs;

    always_comb begin
        src_ext    = {{PAD_W{1'b0}}, src_i};
        stride_ofs = wide_i ? (src_ext << WIDE_SHIFT) : (src_ext << NARROW_SHIFT);
        entry_o    = base_i + stride_ofs;
    end
endmodule

// File: rtl/msi_entry_decode.sv
module msi_entry_decode
    import msi_pq_pkg::*;
#(
    parameter int PRIO_LSB   = 56,
    parameter int PRIO_W     = 8,
    parameter int SERVER_LSB = 40,
    parameter int SERVER_W   = 16,
    parameter int LINK_W     = 2,
    parameter int P_BIT      = 24,
    parameter int Q_BIT      = 16,
    parameter int GEN_LSB    = 25,
    parameter int GEN_W      = 2
) (
    input  logic [63:0]                entry_i,
    input  logic                       force_i,
    output gate_action_e               action_o,
    output logic [SERVER_W-LINK_W-1:0] server_o,
    output logic [PRIO_W-1:0]          prio_o,
    output logic [7:0]                 pbyte_o
);
    localparam int SRV_OUT_W = SERVER_W - LINK_W;

    logic [SERVER_W-1:0] server_raw;
    logic [GEN_W-1:0]    gen;
    logic [1:0]          pq;
    logic                masked;

    always_comb begin
        server_raw = entry_i[SERVER_LSB +: SERVER_W];
        server_o   = server_raw[SERVER_W-1 -: SRV_OUT_W];
        prio_o     = entry_i[PRIO_LSB +: PRIO_W];
        gen        = entry_i[GEN_LSB +: GEN_W];
        masked     = &prio_o;
        pq         = force_i ? 2'b00 : {entry_i[P_BIT], entry_i[Q_BIT]};

        pbyte_o            = 8'h01;
        pbyte_o[GEN_W:1]   = gen;

        unique case (pq)
            2'b00:   action_o = masked ? ACT_QUEUE : ACT_SEND;
            2'b10:   action_o = ACT_QUEUE;
            default: action_o = ACT_DROP;
        endcase
    end
endmodule

// File: rtl/msi_pq_gate.sv
module msi_pq_gate
    import msi_pq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SRC_W      = 11,
    parameter int IRQ_W      = 20,
    parameter int PRIO_LSB   = 56,
    parameter int PRIO_W     = 8,
    parameter int SERVER_LSB = 40,
    parameter int SERVER_W   = 16,
    parameter int P_BIT      = 24,
    parameter int Q_BIT      = 16,
    parameter int GEN_LSB    = 25,
    parameter int GEN_W      = 2,
    parameter int P_OFS      = 4,
    parameter int Q_OFS      = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_tbl_en,
    input  logic [ADDR_W-1:0]     cfg_tbl_base,
    input  logic [SRC_W:0]        cfg_tbl_len,
    input  logic                  cfg_wide_entry,
    input  logic [IRQ_W-1:0]      cfg_irq_base,
    input  logic                  evt_valid,
    output logic                  evt_ready,
    input  logic [SRC_W-1:0]      evt_src,
    input  logic                  evt_force,
    output logic                  rd_req_valid,
    input  logic                  rd_req_ready,
    output logic [ADDR_W-1:0]     rd_req_addr,
    input  logic                  rd_rsp_valid,
    input  logic [63:0]           rd_rsp_data,
    input  logic                  rd_rsp_err,
    output logic                  wr_req_valid,
    input  logic                  wr_req_ready,
    output logic [ADDR_W-1:0]     wr_req_addr,
    output logic [7:0]            wr_req_byte,
    input  logic                  wr_ack_valid,
    output logic                  irq_valid,
    output logic [SERVER_W-3:0]   irq_server,
    output logic [IRQ_W-1:0]      irq_num,
    output logic [PRIO_W-1:0]     irq_prio,
    output logic                  err_pulse
);
    localparam int LINK_W = 2;
    localparam int SRV_W  = SERVER_W - LINK_W;
    localparam int IRQ_PAD = IRQ_W - SRC_W;

    typedef struct packed {
        gate_state_e         st;
        logic [SRC_W-1:0]    src;
        logic                frc;
        logic [ADDR_W-1:0]   entry;
        logic [ADDR_W-1:0]   waddr;
        logic [7:0]          wbyte;
        logic                send;
        logic                irq_v;
        logic [SRV_W-1:0]    srv;
        logic [IRQ_W-1:0]    num;
        logic [PRIO_W-1:0]   prio;
        logic                err;
    } gate_regs_t;

    gate_regs_t r_d, r_q;

    logic [ADDR_W-1:0] evt_entry;
    gate_action_e      act;
    logic [SRV_W-1:0]  dec_server;
    logic [PRIO_W-1:0] dec_prio;
    logic [7:0]        dec_pbyte;
    logic              src_in_range;

    msi_entry_addr #(
        .ADDR_W       (ADDR_W),
        .SRC_W        (SRC_W),
        .WIDE_SHIFT   (7),
        .NARROW_SHIFT (4)
    ) u_addr (
        .base_i  (cfg_tbl_base),
        .src_i   (evt_src),
        .wide_i  (cfg_wide_entry),
        .entry_o (evt_entry)
    );

    msi_entry_decode #(
        .PRIO_LSB   (PRIO_LSB),
        .PRIO_W     (PRIO_W),
        .SERVER_LSB (SERVER_LSB),
        .SERVER_W   (SERVER_W),
        .LINK_W     (LINK_W),
        .P_BIT      (P_BIT),
        .Q_BIT      (Q_BIT),
        .GEN_LSB    (GEN_LSB),
        .GEN_W      (GEN_W)
    ) u_decode (
        .entry_i  (rd_rsp_data),
        .force_i  (r_q.frc),
        .action_o (act),
        .server_o (dec_server),
        .prio_o   (dec_prio),
        .pbyte_o  (dec_pbyte)
    );

    always_comb begin
        src_in_range = ({1'b0, evt_src} < cfg_tbl_len);
        r_d          = r_q;
        r_d.irq_v    = 1'b0;
        r_d.err      = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (evt_valid) begin
                    if (cfg_tbl_en && src_in_range) begin
                        r_d.st    = ST_RD_REQ;
                        r_d.src   = evt_src;
                        r_d.frc   = evt_force;
                        r_d.entry = evt_entry;
                    end else begin
                        r_d.err = 1'b1;
                    end
                end
            end
            ST_RD_REQ: begin
                if (rd_req_ready) begin
                    r_d.st = ST_RD_WAIT;
                end
            end
            ST_RD_WAIT: begin
                if (rd_rsp_valid) begin
                    if (rd_rsp_err) begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_IDLE;
                    end else begin
                        unique case (act)
                            ACT_SEND: begin
                                r_d.st    = ST_WR_REQ;
                                r_d.waddr = r_q.entry + ADDR_W'(P_OFS);
                                r_d.wbyte = dec_pbyte;
                                r_d.send  = 1'b1;
                                r_d.srv   = dec_server;
                                r_d.prio  = dec_prio;
                                r_d.num   = {{IRQ_PAD{1'b0}}, r_q.src} + cfg_irq_base;
                            end
                            ACT_QUEUE: begin
                                r_d.st    = ST_WR_REQ;
                                r_d.waddr = r_q.entry + ADDR_W'(Q_OFS);
                                r_d.wbyte = 8'h01;
                                r_d.send  = 1'b0;
                            end
                            default: begin
                                r_d.st = ST_IDLE;
                            end
                        endcase
                    end
                end
            end
            ST_WR_REQ: begin
                if (wr_req_ready) begin
                    r_d.st = ST_WR_WAIT;
                end
            end
            ST_WR_WAIT: begin
                if (wr_ack_valid) begin
                    r_d.irq_v = r_q.send;
                    r_d.st    = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        evt_ready    = (r_q.st == ST_IDLE);
        rd_req_valid = (r_q.st == ST_RD_REQ);
        rd_req_addr  = r_q.entry;
        wr_req_valid = (r_q.st == ST_WR_REQ);
        wr_req_addr  = r_q.waddr;
        wr_req_byte  = r_q.wbyte;
        irq_valid    = r_q.irq_v;
        irq_server   = r_q.srv;
        irq_num      = r_q.num;
        irq_prio     = r_q.prio;
        err_pulse    = r_q.err;
    end

    // R1
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

    // R3
    irq_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> $past(wr_ack_valid));

    // R4
    byte_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_valid |-> wr_req_byte[0]);

    // R2
    err_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_pulse && irq_valid));

    // R9
    busy_when_writing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_valid |-> !evt_ready);

    // R9
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_valid && wr_req_valid));

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> evt_ready && !rd_req_valid && !wr_req_valid && !irq_valid);

endmodule

// File: tb/msi_pq_gate_tb.sv
module msi_pq_gate_tb;
    localparam int ADDR_W = 32;
    localparam int SRC_W  = 11;
    localparam int IRQ_W  = 20;
    localparam int MEM_N  = 2048;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              cfg_tbl_en = 1'b1;
    logic [ADDR_W-1:0] cfg_tbl_base = 32'h200;
    logic [SRC_W:0]    cfg_tbl_len = 12'd16;
    logic              cfg_wide_entry = 1'b0;
    logic [IRQ_W-1:0]  cfg_irq_base = 20'h01000;
    logic              evt_valid = 1'b0;
    logic              evt_ready;
    logic [SRC_W-1:0]  evt_src = '0;
    logic              evt_force = 1'b0;
    logic              rd_req_valid;
    logic              rd_req_ready = 1'b1;
    logic [ADDR_W-1:0] rd_req_addr;
    logic              rd_rsp_valid;
    logic [63:0]       rd_rsp_data;
    logic              rd_rsp_err;
    logic              wr_req_valid;
    logic              wr_req_ready = 1'b1;
    logic [ADDR_W-1:0] wr_req_addr;
    logic [7:0]        wr_req_byte;
    logic              wr_ack_valid;
    logic              irq_valid;
    logic [13:0]       irq_server;
    logic [IRQ_W-1:0]  irq_num;
    logic [7:0]        irq_prio;
    logic              err_pulse;

    msi_pq_gate u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_tbl_en(cfg_tbl_en), .cfg_tbl_base(cfg_tbl_base), .cfg_tbl_len(cfg_tbl_len),
        .cfg_wide_entry(cfg_wide_entry), .cfg_irq_base(cfg_irq_base),
        .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_src(evt_src), .evt_force(evt_force),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err),
        .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready), .wr_req_addr(wr_req_addr),
        .wr_req_byte(wr_req_byte), .wr_ack_valid(wr_ack_valid),
        .irq_valid(irq_valid), .irq_server(irq_server), .irq_num(irq_num), .irq_prio(irq_prio),
        .err_pulse(err_pulse)
    );

    // memory model with a host poke port
    logic [7:0]  mem [MEM_N];
    logic        poke_en = 1'b0;
    logic [10:0] poke_addr = '0;
    logic [7:0]  poke_byte = '0;
    logic        inject_err = 1'b0;

    int cyc = 0, rd_cnt = 0, wr_cnt = 0, irq_cnt = 0, err_cnt = 0;
    int ack_cyc = 0, irq_cyc = 0;
    logic [ADDR_W-1:0] last_rd_addr = '0;
    logic [13:0]       last_srv = '0;
    logic [IRQ_W-1:0]  last_num = '0;
    logic [7:0]        last_prio = '0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        rd_rsp_valid <= 1'b0;
        wr_ack_valid <= 1'b0;
        rd_rsp_err   <= 1'b0;
        if (!rst_n) begin
            for (int i = 0; i < MEM_N; i++) mem[i] <= 8'h00;
            rd_rsp_data <= '0;
        end else begin
            if (poke_en) mem[poke_addr] <= poke_byte;
            if (rd_req_valid && rd_req_ready) begin
                rd_cnt       <= rd_cnt + 1;
                last_rd_addr <= rd_req_addr;
                rd_rsp_valid <= 1'b1;
                rd_rsp_err   <= inject_err;
                for (int k = 0; k < 8; k++)
                    rd_rsp_data[63-8*k -: 8] <= mem[11'(rd_req_addr + 32'(k))];
            end
            if (wr_req_valid && wr_req_ready) begin
                wr_cnt <= wr_cnt + 1;
                mem[11'(wr_req_addr)] <= wr_req_byte;
                wr_ack_valid <= 1'b1;
            end
            if (wr_ack_valid) ack_cyc <= cyc;
            if (irq_valid) begin
                irq_cnt   <= irq_cnt + 1;
                irq_cyc   <= cyc;
                last_srv  <= irq_server;
                last_num  <= irq_num;
                last_prio <= irq_prio;
            end
            if (err_pulse) err_cnt <= err_cnt + 1;
        end
    end

    int total = 0, fails = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic poke(input int addr, input logic [7:0] b);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = 11'(addr); poke_byte = b;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic put_entry(input int ent, input logic [7:0] prio, input logic [15:0] srv,
                             input bit p, input bit q, input logic [1:0] gen);
        poke(ent + 0, prio);
        poke(ent + 1, srv[15:8]);
        poke(ent + 2, srv[7:0]);
        poke(ent + 3, 8'h00);
        poke(ent + 4, {5'b0, gen, p});
        poke(ent + 5, {7'b0, q});
        poke(ent + 6, 8'h00);
        poke(ent + 7, 8'h00);
    endtask

    task automatic send_evt(input int src, input bit frc);
        @(negedge clk);
        evt_valid = 1'b1; evt_src = 11'(src); evt_force = frc;
        @(posedge clk);
        #1 evt_valid = 1'b0; evt_force = 1'b0;
        for (int n = 0; n < 50 && !evt_ready; n++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        check(evt_ready == 1'b1, "R10 ready", longint'(evt_ready), 1);
        check(!rd_req_valid && !wr_req_valid, "R10 ports idle", longint'({rd_req_valid, wr_req_valid}), 0);
        check(!irq_valid && !err_pulse, "R10 no pulses", longint'({irq_valid, err_pulse}), 0);
    endtask

    task automatic t_send_narrow();
        int w0 = wr_cnt, i0 = irq_cnt;
        put_entry(32'h250, 8'h05, 16'h048F, 1'b0, 1'b0, 2'd2);
        send_evt(5, 1'b0);
        check(last_rd_addr == 32'h250, "R1 narrow addr", longint'(last_rd_addr), 32'h250);
        check(mem[11'h254] == 8'h05, "R3 pbyte", longint'(mem[11'h254]), 8'h05);
        check(mem[11'h255] == 8'h00, "R3 q untouched", longint'(mem[11'h255]), 0);
        check(wr_cnt == w0 + 1, "R3 one write", longint'(wr_cnt - w0), 1);
        check(irq_cnt == i0 + 1, "R3 irq count", longint'(irq_cnt - i0), 1);
        check(last_srv == 14'h123, "R3 server", longint'(last_srv), 14'h123);
        check(last_num == 20'h01005, "R3 number", longint'(last_num), 20'h01005);
        check(last_prio == 8'h05, "R3 prio", longint'(last_prio), 5);
    endtask

    task automatic t_masked();
        int i0 = irq_cnt;
        put_entry(32'h260, 8'hFF, 16'h0010, 1'b0, 1'b0, 2'd1);
        send_evt(6, 1'b0);
        check(mem[11'h265] == 8'h01, "R4 q set", longint'(mem[11'h265]), 1);
        check(mem[11'h264] == 8'h02, "R4 p byte unchanged", longint'(mem[11'h264]), 2);
        check(irq_cnt == i0, "R4 no irq", longint'(irq_cnt - i0), 0);
    endtask

    task automatic t_pending();
        int i0 = irq_cnt;
        put_entry(32'h270, 8'h04, 16'h0010, 1'b1, 1'b0, 2'd0);
        send_evt(7, 1'b0);
        check(mem[11'h275] == 8'h01, "R5 q set", longint'(mem[11'h275]), 1);
        check(irq_cnt == i0, "R5 no irq", longint'(irq_cnt - i0), 0);
    endtask

    task automatic t_drop();
        int w0, i0;
        put_entry(32'h280, 8'h04, 16'h0010, 1'b0, 1'b1, 2'd0);
        put_entry(32'h290, 8'h04, 16'h0010, 1'b1, 1'b1, 2'd0);
        w0 = wr_cnt; i0 = irq_cnt;
        send_evt(8, 1'b0);
        send_evt(9, 1'b0);
        check(wr_cnt == w0, "R6 no write", longint'(wr_cnt - w0), 0);
        check(irq_cnt == i0, "R6 no irq", longint'(irq_cnt - i0), 0);
        check(mem[11'h284] == 8'h00 && mem[11'h294] == 8'h01, "R6 entries intact",
              longint'({mem[11'h284], mem[11'h294]}), 16'h0001);
    endtask

    task automatic t_force();
        int i0 = irq_cnt;
        put_entry(32'h2A0, 8'h03, 16'h0020, 1'b1, 1'b1, 2'd1);
        send_evt(10, 1'b1);
        check(irq_cnt == i0 + 1, "R7 forced irq", longint'(irq_cnt - i0), 1);
        check(mem[11'h2A4] == 8'h03, "R7 pbyte", longint'(mem[11'h2A4]), 3);
        check(last_num == 20'h0100A, "R7 number", longint'(last_num), 20'h0100A);
    endtask

    task automatic t_wide();
        int i0 = irq_cnt;
        cfg_wide_entry = 1'b1;
        put_entry(32'h380, 8'h07, 16'h0008, 1'b0, 1'b0, 2'd0);
        send_evt(3, 1'b0);
        cfg_wide_entry = 1'b0;
        check(last_rd_addr == 32'h380, "R1 wide addr", longint'(last_rd_addr), 32'h380);
        check(mem[11'h384] == 8'h01, "R1 wide pbyte", longint'(mem[11'h384]), 1);
        check(mem[11'h234] == 8'h00, "R1 narrow slot untouched", longint'(mem[11'h234]), 0);
        check(irq_cnt == i0 + 1 && last_srv == 14'h002, "R1 wide irq", longint'(last_srv), 2);
    endtask

    task automatic t_bad_cfg();
        int r0 = rd_cnt, e0 = err_cnt, i0 = irq_cnt;
        cfg_tbl_en = 1'b0;
        send_evt(5, 1'b0);
        cfg_tbl_en = 1'b1;
        check(err_cnt == e0 + 1, "R2 disabled err", longint'(err_cnt - e0), 1);
        send_evt(16, 1'b0);
        check(err_cnt == e0 + 2, "R2 range err", longint'(err_cnt - e0), 2);
        check(rd_cnt == r0, "R2 no read", longint'(rd_cnt - r0), 0);
        check(irq_cnt == i0, "R2 no irq", longint'(irq_cnt - i0), 0);
    endtask

    task automatic t_read_err();
        int w0 = wr_cnt, e0 = err_cnt, i0 = irq_cnt;
        put_entry(32'h2B0, 8'h02, 16'h0010, 1'b0, 1'b0, 2'd0);
        inject_err = 1'b1;
        send_evt(11, 1'b0);
        inject_err = 1'b0;
        check(err_cnt == e0 + 1, "R8 err", longint'(err_cnt - e0), 1);
        check(wr_cnt == w0 && irq_cnt == i0, "R8 nothing written", longint'(wr_cnt - w0), 0);
        check(mem[11'h2B4] == 8'h00, "R8 entry intact", longint'(mem[11'h2B4]), 0);
    endtask

    task automatic t_order();
        put_entry(32'h2C0, 8'h01, 16'h0010, 1'b0, 1'b0, 2'd0);
        @(negedge clk);
        evt_valid = 1'b1; evt_src = 11'd12; evt_force = 1'b0;
        @(posedge clk);
        #1 evt_valid = 1'b0;
        @(negedge clk);
        check(evt_ready == 1'b0, "R9 busy", longint'(evt_ready), 0);
        for (int n = 0; n < 50 && !evt_ready; n++) @(negedge clk);
        repeat (3) @(negedge clk);
        check(irq_cyc == ack_cyc + 1, "R9 irq after ack", longint'(irq_cyc - ack_cyc), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_send_narrow();
        t_masked();
        t_pending();
        t_drop();
        t_force();
        t_wide();
        t_bad_cfg();
        t_read_err();
        t_order();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule